// File: doc/BRIEF.md
# DMX512 Frame Generator

This block turns a 512-entry byte buffer into a DMX512-style serial stream on one output line. Each frame opens with a long low break and a short high mark, then sends a zero start-code slot followed by a programmable number of data slots. Every slot is eight data bits framed with one start bit and two stop bits at 250 kbit/s. A programmable idle gap can be placed between slots. The time from one break to the next is set in microseconds, independently of the slot count and the gap.

The host writes slot data through a simple write port, sets up slot count, gap and refresh period, and then raises the enable input. All timing runs in whole microseconds from a tick that a parameterized divider derives from the system clock. The sequencer is an eight-state machine. Its transitions are listed below.

- IDLE→BREAK on a tick with enable high.
- BREAK→MAB after 176 µs, or BREAK→IDLE at that point if enable is low.
- MAB→START after 12 µs, or MAB→IDLE at that point if enable is low.
- START→DATA after 4 µs.
- DATA→DATA after each 4 µs bit, and DATA→STOP after the eighth bit.
- STOP→GAP after 8 µs when a gap is set and more slots remain.
- STOP→START after 8 µs with no gap and more slots remaining.
- STOP→FILL after the last slot while the refresh period is still running.
- STOP→BREAK after the last slot once the refresh period has elapsed.
- STOP→IDLE after 8 µs if enable is low.
- GAP→START when the gap time has elapsed.
- FILL→BREAK when the refresh period has elapsed.
- GAP→IDLE and FILL→IDLE on any tick with enable low.

Top module: `dmx_frame_gen`

## Requirements
- R1: While reset is held, and whenever generation is idle, `dmx_out` is 1.
- R2: One microsecond tick occurs every `CLK_PER_US` clocks, counted from the first clock edge after reset. The line changes state only on tick edges, and each level holds for a whole number of microseconds.
- R3: A frame starts on the first tick edge at which enable is 1. It begins with 176 µs low (break) and then 12 µs high (mark after break).
- R4: Each slot is 4 µs low, then eight data bits of 4 µs each sent least significant bit first, then 8 µs high. The first slot of every frame carries 0x00.
- R5: Data slot k (1 ≤ k ≤ count) carries the byte held at buffer address k−1. A buffer byte is written on a clock edge where `buf_we` is 1.
- R6: Between the stop bits of one slot and the start bit of the next, the line stays high for `gap_us` µs. No gap follows the last slot, and a gap of 0 sends slots back to back.
- R7: If the frame content is shorter than `period_us`, the next break starts `period_us` µs after the previous one. Otherwise it starts right after the last slot's stop bits.
- R8: A slot count of 0 sends one data slot. A slot count above 512 sends 512 data slots.
- R9: Slot count, gap and period are captured when a break starts. Changing them mid-frame affects only the following frames.
- R10: When enable is low at the end of a break, a mark or a slot's stop bits, or during a gap or the period fill, the line goes idle high. A break, mark or slot that has begun is always completed. Raising enable again starts a break on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Generation enable |
| slot_count | input | 16 | Data slots per frame (clamped to 1..512) |
| gap_us | input | 16 | Idle time between slots, µs |
| period_us | input | 32 | Break-to-break time, µs |
| buf_we | input | 1 | Buffer write strobe |
| buf_addr | input | 9 | Buffer write address (slot number − 1) |
| buf_wdata | input | 8 | Buffer write data |
| dmx_out | output | 1 | Serial line, idle high |

## Verification
Every line level is due on the same clock edge as the microsecond tick that starts it, because the output register loads from the next-state decode. There is no extra register on the path. The bench keeps its own count of clock edges since reset to place each tick, and pops one expected microsecond level from a queue at that edge. The expected waveform and the output are then compared at every falling edge, half a cycle after the level was due. Buffer and configuration changes are driven on falling edges, so the value captured at a break start is the one seen at that rising edge.

// File: rtl/dmx_gen_pkg.sv
package dmx_gen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_MAB,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_GAP,
        ST_FILL
    } gen_state_e;

endpackage

// File: rtl/dmx_us_tick.sv
module dmx_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_PER_US <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CLK_PER_US);
            localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == LAST)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == LAST);

            // R2: ticks never come on adjacent clocks
            p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/dmx_slot_ram.sv
module dmx_slot_ram #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
        rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/dmx_frame_fsm.sv
module dmx_frame_fsm
    import dmx_gen_pkg::*;
#(
    parameter int BREAK_US  = 176,
    parameter int MAB_US    = 12,
    parameter int BIT_US    = 4,
    parameter int MAX_SLOTS = 512,
    parameter int AW        = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          gen_en,
    input  logic [15:0]   slot_count,
    input  logic [15:0]   gap_us,
    input  logic [31:0]   period_us,
    input  logic [7:0]    rdata,
    output logic [AW-1:0] raddr,
    output logic          line
);
    localparam int SW = $clog2(MAX_SLOTS + 1);
    localparam logic [SW-1:0] MAXN    = SW'(MAX_SLOTS);
    localparam logic [15:0]   BRK_END = 16'(BREAK_US - 1);
    localparam logic [15:0]   MAB_END = 16'(MAB_US - 1);
    localparam logic [15:0]   BIT_END = 16'(BIT_US - 1);
    localparam logic [15:0]   STP_END = 16'(2 * BIT_US - 1);

    gen_state_e    state_q, state_d;
    logic [15:0]   dur_q, dur_d;
    logic [2:0]    bit_q, bit_d;
    logic [SW-1:0] slot_q, slot_d;
    logic [7:0]    sh_q, sh_d;
    logic [31:0]   pc_q, pc_d;
    logic [SW-1:0] n_lat;
    logic [15:0]   gap_lat;
    logic [31:0]   per_lat;
    logic          lat_load;
    logic          line_q, line_d;
    logic [SW-1:0] n_clamp;
    logic          per_done;

    always_comb begin
        if (slot_count == 16'd0)
            n_clamp = SW'(1);
        else if (slot_count > 16'(MAX_SLOTS))
            n_clamp = MAXN;
        else
            n_clamp = SW'(slot_count);
    end

    assign per_done = ({1'b0, pc_q} + 33'd1) >= {1'b0, per_lat};
    assign raddr    = AW'(slot_q - SW'(1));

    // next-state decode
    always_comb begin
        state_d  = state_q;
        dur_d    = dur_q;
        bit_d    = bit_q;
        slot_d   = slot_q;
        sh_d     = sh_q;
        pc_d     = pc_q;
        lat_load = 1'b0;
        if (tick) begin
            pc_d  = (&pc_q) ? pc_q : pc_q + 32'd1;
            dur_d = dur_q + 16'd1;
            unique case (state_q)
                ST_IDLE: begin
                    dur_d = '0;
                    if (gen_en) begin
                        state_d = ST_BREAK; pc_d = '0; lat_load = 1'b1;
                    end
                end
                ST_BREAK: begin
                    if (dur_q == BRK_END) begin
                        dur_d   = '0;
                        state_d = gen_en ? ST_MAB : ST_IDLE;
                    end
                end
                ST_MAB: begin
                    if (dur_q == MAB_END) begin
                        dur_d   = '0;
                        slot_d  = '0;
                        state_d = gen_en ? ST_START : ST_IDLE;
                    end
                end
                ST_START: begin
                    if (dur_q == BIT_END) begin
                        dur_d   = '0;
                        bit_d   = '0;
                        sh_d    = (slot_q == '0) ? 8'h00 : rdata;
                        state_d = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (dur_q == BIT_END) begin
                        dur_d = '0;
                        sh_d  = sh_q >> 1;
                        if (bit_q == 3'd7)
                            state_d = ST_STOP;
                        else
                            bit_d = bit_q + 3'd1;
                    end
                end
                ST_STOP: begin
                    if (dur_q == STP_END) begin
                        dur_d = '0;
                        if (!gen_en) begin
                            state_d = ST_IDLE;
                        end else if (slot_q == n_lat) begin
                            if (per_done) begin
                                state_d = ST_BREAK; pc_d = '0; lat_load = 1'b1;
                            end else begin
                                state_d = ST_FILL;
                            end
                        end else begin
                            slot_d  = slot_q + SW'(1);
                            state_d = (gap_lat == 16'd0) ? ST_START : ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (!gen_en) begin
                        dur_d = '0; state_d = ST_IDLE;
                    end else if (dur_q == gap_lat - 16'd1) begin
                        dur_d = '0; state_d = ST_START;
                    end
                end
                ST_FILL: begin
                    dur_d = '0;
                    if (!gen_en) begin
                        state_d = ST_IDLE;
                    end else if (per_done) begin
                        state_d = ST_BREAK; pc_d = '0; lat_load = 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_d)
            ST_BREAK, ST_START: line_d = 1'b0;
            ST_DATA:            line_d = sh_d[0];
            default:            line_d = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dur_q   <= '0;
            bit_q   <= '0;
            slot_q  <= '0;
            sh_q    <= '0;
            pc_q    <= '0;
            n_lat   <= MAXN;
            gap_lat <= '0;
            per_lat <= '0;
        end else begin
            state_q <= state_d;
            dur_q   <= dur_d;
            bit_q   <= bit_d;
            slot_q  <= slot_d;
            sh_q    <= sh_d;
            pc_q    <= pc_d;
            if (lat_load) begin
                n_lat   <= n_clamp;
                gap_lat <= gap_us;
                per_lat <= period_us;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= 1'b1;
        else
            line_q <= line_d;
    end

    assign line = line_q;

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> line_q);

    p_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(tick));

    p_mab_after_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_MAB) |-> ($past(state_q) == ST_BREAK));

    p_eight_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && $past(state_q) == ST_DATA) |-> ($past(bit_q) == 3'd7));

    p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_START, ST_DATA, ST_STOP, ST_GAP}) |-> (slot_q <= n_lat));

    p_count_clamped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (n_lat != '0 && n_lat <= MAXN));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BREAK || $past(state_q) == ST_BREAK)
            |-> ($stable(n_lat) && $stable(gap_lat) && $stable(per_lat)));
endmodule

// File: rtl/dmx_frame_gen.sv
module dmx_frame_gen #(
    parameter int CLK_PER_US = 50,
    parameter int BREAK_US   = 176,
    parameter int MAB_US     = 12,
    parameter int BIT_US     = 4,
    parameter int MAX_SLOTS  = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         gen_en,
    input  logic [15:0]                  slot_count,
    input  logic [15:0]                  gap_us,
    input  logic [31:0]                  period_us,
    input  logic                         buf_we,
    input  logic [$clog2(MAX_SLOTS)-1:0] buf_addr,
    input  logic [7:0]                   buf_wdata,
    output logic                         dmx_out
);
    localparam int AW = $clog2(MAX_SLOTS);

    logic          tick;
    logic [AW-1:0] raddr;
    logic [7:0]    rdata;

    dmx_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dmx_slot_ram #(.DEPTH(MAX_SLOTS), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_addr),
        .wdata (buf_wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    dmx_frame_fsm #(
        .BREAK_US  (BREAK_US),
        .MAB_US    (MAB_US),
        .BIT_US    (BIT_US),
        .MAX_SLOTS (MAX_SLOTS),
        .AW        (AW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .gen_en     (gen_en),
        .slot_count (slot_count),
        .gap_us     (gap_us),
        .period_us  (period_us),
        .rdata      (rdata),
        .raddr      (raddr),
        .line       (dmx_out)
    );
endmodule

// File: tb/sim_dmx_frame_gen.sv
module sim_dmx_frame_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;
    localparam int WD_LIMIT   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0;
    logic [15:0] slot_count = 16'd1;
    logic [15:0] gap_us = 16'd0;
    logic [31:0] period_us = 32'd0;
    logic        buf_we = 1'b0;
    logic [8:0]  buf_addr = '0;
    logic [7:0]  buf_wdata = '0;
    logic        dmx_out;

    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string phase = "R1 reset";

    bit [7:0] mirror [512];
    bit [1:0] q [$];          // {boundary, level} per microsecond
    bit       exp_line = 1'b1;
    bit       cur_bnd = 1'b1;
    int       edge_n = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dmx_frame_gen #(.CLK_PER_US(CPU)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_en     (gen_en),
        .slot_count (slot_count),
        .gap_us     (gap_us),
        .period_us  (period_us),
        .buf_we     (buf_we),
        .buf_addr   (buf_addr),
        .buf_wdata  (buf_wdata),
        .dmx_out    (dmx_out)
    );

    function automatic void push(bit v, int cnt, bit bnd_last);
        for (int i = 0; i < cnt; i++)
            q.push_back({(i == cnt - 1) ? bnd_last : 1'b0, v});
    endfunction

    function automatic void build_frame();
        int     n;
        longint len;
        bit [7:0] b;
        n = (slot_count == 0) ? 1 : (slot_count > 512) ? 512 : int'(slot_count);
        push(1'b0, 176, 1'b1);
        push(1'b1, 12, 1'b1);
        len = 188;
        for (int s = 0; s <= n; s++) begin
            b = (s == 0) ? 8'h00 : mirror[s - 1];
            push(1'b0, 4, 1'b0);
            for (int k = 0; k < 8; k++) push(b[k], 4, 1'b0);
            push(1'b1, 8, 1'b1);
            len += 44;
            if (s < n && gap_us != 0) begin
                for (int g = 0; g < int'(gap_us); g++) q.push_back(2'b11);
                len += gap_us;
            end
        end
        if (longint'(period_us) > len)
            for (longint f = 0; f < longint'(period_us) - len; f++) q.push_back(2'b11);
    endfunction

    // behavioural reference: one expected level per microsecond
    always @(posedge clk) begin
        if (!rst_n) begin
            edge_n = 0;
            q.delete();
            exp_line = 1'b1;
            cur_bnd  = 1'b1;
        end else begin
            if (edge_n % CPU == CPU - 1) begin
                if (cur_bnd && !gen_en) q.delete();
                if (q.size() == 0 && gen_en) build_frame();
                if (q.size() == 0) begin
                    exp_line = 1'b1;
                    cur_bnd  = 1'b1;
                end else begin
                    {cur_bnd, exp_line} = q.pop_front();
                end
            end
            edge_n++;
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            tests++;
            if (dmx_out !== exp_line) begin
                fails++;
                if (fails < 20)
                    $display("FAIL %s at cycle %0d: dmx_out=%b expected=%b", phase, cyc, dmx_out, exp_line);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic wait_us(int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    task automatic cfg(int n, int g, int p);
        slot_count = 16'(n);
        gap_us     = 16'(g);
        period_us  = 32'(p);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        tests++;
        if (dmx_out !== 1'b1) begin
            fails++;
            $display("FAIL R1 in reset: dmx_out=%b expected=1", dmx_out);
        end
        rst_n = 1'b1;

        // R5: fill the buffer while idle
        phase = "R1 R5 idle during buffer load";
        for (int i = 0; i < 512; i++) begin
            buf_we    = 1'b1;
            buf_addr  = 9'(i);
            buf_wdata = 8'((i * 37 + 11) & 255);
            mirror[i] = 8'((i * 37 + 11) & 255);
            @(negedge clk);
        end
        buf_we = 1'b0;
        wait_us(50);

        phase = "R2 R3 R4 R5 R7 short frame with period fill";
        cfg(3, 0, 400);
        gen_en = 1'b1;
        wait_us(850);

        phase = "R9 config change mid frame";
        cfg(4, 5, 100);
        wait_us(100);

        phase = "R6 R7 gap and content longer than period";
        wait_us(900);

        phase = "R8 slot count zero, back to back";
        cfg(0, 0, 0);
        wait_us(600);

        phase = "R8 slot count above maximum";
        cfg(600, 0, 0);
        wait_us(23300);

        phase = "R10 disable during break";
        gen_en = 1'b0;
        cfg(2, 3, 0);
        wait_us(300);
        gen_en = 1'b1;
        wait_us(100);
        gen_en = 1'b0;
        wait_us(300);

        phase = "R10 disable inside a data slot";
        gen_en = 1'b1;
        wait_us(205);
        gen_en = 1'b0;
        wait_us(200);

        phase = "R10 disable inside a gap";
        gen_en = 1'b1;
        wait_us(233);
        gen_en = 1'b0;
        wait_us(3);
        gen_en = 1'b1;
        wait_us(400);
        gen_en = 1'b0;
        wait_us(150);

        phase = "R1 idle after stop";
        wait_us(50);
        summary();
    end
endmodule